// File: doc/BRIEF.md
# SLC-96 Overhead Field Holder

This block sits behind the framer of a T1 receive path running the SLC-96 superframe format. The framer has already found alignment and pulled out, once per superframe, four overhead codes: the concentrator field, the maintenance field, the alarm field and the switch field. Each field arrives on its own bus with its own one-cycle valid strobe. The block keeps a held copy of each code for the host to read.

A debounce enable selects how a held copy is refreshed. With debounce off, every accepted strobe loads its code straight into the held copy. With debounce on, a field loads only when its code matches the code accepted on that field's previous strobe. Each field keeps a one-entry comparison register that reloads on every accepted strobe, so every field runs its own two-superframe agreement filter. While the in-sync flag is low, strobes are ignored and the held copies and comparison registers do not move.

Each field has a sticky change flag. It is set whenever a load gives the held copy a value that differs from its previous one, in either debounce mode. A one-cycle write-one-to-clear input clears it. The first load after reset never sets a flag. The reset input is asserted asynchronously and released in step with the clock.

Top module: `slc_ovh_extract`

## Requirements
- R1: While rst_n is low, all held values and all change flags read 0. After rst_n rises the block takes strobes within four clock cycles.
- R2: With debounce_en = 0 and in_sync = 1, a strobe on field bit i loads that field's code into its held output. The value shows on the output in the cycle after the strobe cycle.
- R3: With debounce_en = 1 and in_sync = 1, a strobe loads the held output only if the code equals the code of that field's previous accepted strobe. Otherwise the held output keeps its value.
- R4: Every accepted strobe replaces the comparison code of its field, whether or not it loads. The sequence A, B, A therefore never loads A a second time in debounce mode, while A, B, B loads B on the third strobe.
- R5: While in_sync = 0, strobes have no effect. Held outputs and comparison codes stay as they were.
- R6: A load that gives the held output a different value sets that field's change flag on the same clock edge as the load. A load of the same value leaves the flag unchanged. This holds in both debounce modes.
- R7: The first load of each field after reset does not set its change flag, even when the loaded value is nonzero.
- R8: A change flag stays at 1 until a cycle with chg_clr bit i = 1, which clears it on the next edge. If a setting load and a clear fall in the same cycle, the flag ends at 1.
- R9: Strobe, clear and flag bit positions are bit 0 for concentrator, bit 1 for maintenance, bit 2 for alarm and bit 3 for switch. A strobe or clear on one bit changes no other field's held value or flag.
- R10: Field widths are parameters with defaults of 11 bits for concentrator, 3 for maintenance, 2 for alarm and 4 for switch. The full-scale value of each field is loaded and held intact.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asserted asynchronously |
| in_sync | input | 1 | 1 while the framer holds SLC-96 alignment |
| debounce_en | input | 1 | 1 selects the two-superframe agreement filter |
| fld_stb | input | 4 | Per-field code-valid strobes (bit map per R9) |
| conc_code | input | CONC_W | Received concentrator code |
| maint_code | input | MAINT_W | Received maintenance code |
| alarm_code | input | ALARM_W | Received alarm code |
| switch_code | input | SWITCH_W | Received switch code |
| chg_clr | input | 4 | Write-one-to-clear pulses for the change flags |
| conc_hold | output | CONC_W | Held concentrator value |
| maint_hold | output | MAINT_W | Held maintenance value |
| alarm_hold | output | ALARM_W | Held alarm value |
| switch_hold | output | SWITCH_W | Held switch value |
| chg_flag | output | 4 | Sticky change flags |

## Verification
On every cycle, the assertions check that held values stay frozen while alignment is lost or no strobe is present, and that a non-debounced strobe loads its code exactly. They also check that a flag only rises together with a change of its held value and stays set until a clear. Only the bench scenarios can show the debounce sequencing: the comparison code reloading on non-matching strobes, and A, B, A failing where A, B, B succeeds. The same holds for the silent first load after reset, for set winning over a simultaneous clear, and for frozen comparison codes across a loss of sync. The bench sweeps every three-code sequence of the alarm field in both modes and every code pair of the maintenance field with debounce on, and compares all four fields after each step.

// File: rtl/slc_ovh_pkg.sv
package slc_ovh_pkg;
  localparam int NUM_FIELDS = 4;

  typedef enum logic [1:0] {
    FLD_CONC   = 2'd0,
    FLD_MAINT  = 2'd1,
    FLD_ALARM  = 2'd2,
    FLD_SWITCH = 2'd3
  } field_e;

  function automatic int max4(input int a, input int b, input int c, input int d);
    int m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    return m;
  endfunction
endpackage

// File: rtl/ovh_rst_sync.sv
module ovh_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q    <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      stage_q    <= 1'b1;
      rst_sync_n <= stage_q;
    end
  end
endmodule

// File: rtl/ovh_field_filter.sv
module ovh_field_filter #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         stb,
  input  logic         in_sync,
  input  logic         deb_en,
  input  logic [W-1:0] code,
  output logic [W-1:0] held,
  output logic         chg_evt
);
  logic [W-1:0] cmp_q, cmp_d;
  logic [W-1:0] held_q, held_d;
  logic         primed_q, primed_d;
  logic         take, agree, load;

  // next-state
  always_comb begin
    take     = stb & in_sync;
    agree    = (code == cmp_q);
    load     = take & (~deb_en | agree);
    cmp_d    = take ? code : cmp_q;
    held_d   = load ? code : held_q;
    primed_d = primed_q | load;
    chg_evt  = load & primed_q & (code != held_q);
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmp_q    <= '0;
      held_q   <= '0;
      primed_q <= 1'b0;
    end else begin
      if (take) cmp_q <= cmp_d;
      if (load) begin
        held_q   <= held_d;
        primed_q <= primed_d;
      end
    end
  end

  assign held = held_q;
endmodule

// File: rtl/ovh_change_flag.sv
module ovh_change_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  output logic flag
);
  logic flag_q, flag_d;
  logic flag_en;

  always_comb begin
    flag_en = set | clr;
    flag_d  = set | (flag_q & ~clr);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= 1'b0;
    else if (flag_en) flag_q <= flag_d;
  end

  assign flag = flag_q;
endmodule

// File: rtl/slc_ovh_extract.sv
module slc_ovh_extract
  import slc_ovh_pkg::*;
#(
  parameter int CONC_W   = 11,
  parameter int MAINT_W  = 3,
  parameter int ALARM_W  = 2,
  parameter int SWITCH_W = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  in_sync,
  input  logic                  debounce_en,
  input  logic [NUM_FIELDS-1:0] fld_stb,
  input  logic [CONC_W-1:0]     conc_code,
  input  logic [MAINT_W-1:0]    maint_code,
  input  logic [ALARM_W-1:0]    alarm_code,
  input  logic [SWITCH_W-1:0]   switch_code,
  input  logic [NUM_FIELDS-1:0] chg_clr,
  output logic [CONC_W-1:0]     conc_hold,
  output logic [MAINT_W-1:0]    maint_hold,
  output logic [ALARM_W-1:0]    alarm_hold,
  output logic [SWITCH_W-1:0]   switch_hold,
  output logic [NUM_FIELDS-1:0] chg_flag
);
  localparam int OFF_CONC   = 0;
  localparam int OFF_MAINT  = OFF_CONC + CONC_W;
  localparam int OFF_ALARM  = OFF_MAINT + MAINT_W;
  localparam int OFF_SWITCH = OFF_ALARM + ALARM_W;
  localparam int TOTAL_W    = OFF_SWITCH + SWITCH_W;

  logic                  rst_sync_n;
  logic [TOTAL_W-1:0]    code_bus;
  logic [TOTAL_W-1:0]    held_bus;
  logic [NUM_FIELDS-1:0] chg_evt;

  ovh_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  assign code_bus = {switch_code, alarm_code, maint_code, conc_code};

  for (genvar i = 0; i < NUM_FIELDS; i++) begin : g_field
    localparam int FW  = (i == int'(FLD_CONC))  ? CONC_W  :
                         (i == int'(FLD_MAINT)) ? MAINT_W :
                         (i == int'(FLD_ALARM)) ? ALARM_W : SWITCH_W;
    localparam int OFF = (i == int'(FLD_CONC))  ? OFF_CONC  :
                         (i == int'(FLD_MAINT)) ? OFF_MAINT :
                         (i == int'(FLD_ALARM)) ? OFF_ALARM : OFF_SWITCH;

    ovh_field_filter #(.W(FW)) u_filt (
      .clk     (clk),
      .rst_n   (rst_sync_n),
      .stb     (fld_stb[i]),
      .in_sync (in_sync),
      .deb_en  (debounce_en),
      .code    (code_bus[OFF +: FW]),
      .held    (held_bus[OFF +: FW]),
      .chg_evt (chg_evt[i])
    );

    ovh_change_flag u_flag (
      .clk   (clk),
      .rst_n (rst_sync_n),
      .set   (chg_evt[i]),
      .clr   (chg_clr[i]),
      .flag  (chg_flag[i])
    );
  end

  assign conc_hold   = held_bus[OFF_CONC   +: CONC_W];
  assign maint_hold  = held_bus[OFF_MAINT  +: MAINT_W];
  assign alarm_hold  = held_bus[OFF_ALARM  +: ALARM_W];
  assign switch_hold = held_bus[OFF_SWITCH +: SWITCH_W];
endmodule

// File: rtl/slc_ovh_chk.sv
module slc_ovh_chk
  import slc_ovh_pkg::*;
#(
  parameter int CONC_W   = 11,
  parameter int MAINT_W  = 3,
  parameter int ALARM_W  = 2,
  parameter int SWITCH_W = 4
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  in_sync,
  input logic                  debounce_en,
  input logic [NUM_FIELDS-1:0] fld_stb,
  input logic [CONC_W-1:0]     conc_code,
  input logic [MAINT_W-1:0]    maint_code,
  input logic [ALARM_W-1:0]    alarm_code,
  input logic [SWITCH_W-1:0]   switch_code,
  input logic [NUM_FIELDS-1:0] chg_clr,
  input logic [CONC_W-1:0]     conc_hold,
  input logic [MAINT_W-1:0]    maint_hold,
  input logic [ALARM_W-1:0]    alarm_hold,
  input logic [SWITCH_W-1:0]   switch_hold,
  input logic [NUM_FIELDS-1:0] chg_flag
);
  localparam int MW = max4(CONC_W, MAINT_W, ALARM_W, SWITCH_W);

  logic [MW-1:0] h [NUM_FIELDS];
  logic [MW-1:0] c [NUM_FIELDS];

  always_comb begin
    for (int k = 0; k < NUM_FIELDS; k++) begin
      h[k] = '0;
      c[k] = '0;
    end
    h[0][CONC_W-1:0]   = conc_hold;
    h[1][MAINT_W-1:0]  = maint_hold;
    h[2][ALARM_W-1:0]  = alarm_hold;
    h[3][SWITCH_W-1:0] = switch_hold;
    c[0][CONC_W-1:0]   = conc_code;
    c[1][MAINT_W-1:0]  = maint_code;
    c[2][ALARM_W-1:0]  = alarm_code;
    c[3][SWITCH_W-1:0] = switch_code;
  end

  for (genvar i = 0; i < NUM_FIELDS; i++) begin : g_chk
    assert_frozen_out_of_sync_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !in_sync |=> $stable(h[i]));

    assert_idle_field_stable_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !fld_stb[i] |=> $stable(h[i]));

    assert_direct_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (fld_stb[i] && in_sync && !debounce_en) |=> (h[i] == $past(c[i])));

    assert_flag_needs_change_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(chg_flag[i]) |-> !$stable(h[i]));

    assert_flag_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (chg_flag[i] && !chg_clr[i]) |=> chg_flag[i]);
  end
endmodule

bind slc_ovh_extract slc_ovh_chk #(
  .CONC_W(CONC_W), .MAINT_W(MAINT_W), .ALARM_W(ALARM_W), .SWITCH_W(SWITCH_W)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_sync_n),
  .in_sync     (in_sync),
  .debounce_en (debounce_en),
  .fld_stb     (fld_stb),
  .conc_code   (conc_code),
  .maint_code  (maint_code),
  .alarm_code  (alarm_code),
  .switch_code (switch_code),
  .chg_clr     (chg_clr),
  .conc_hold   (conc_hold),
  .maint_hold  (maint_hold),
  .alarm_hold  (alarm_hold),
  .switch_hold (switch_hold),
  .chg_flag    (chg_flag)
);

// File: tb/slc_ovh_extract_test.sv
`timescale 1ns/1ps
module slc_ovh_extract_test;
  localparam int FW [4] = '{11, 3, 2, 4};

  logic        clk;
  logic        rst_n;
  logic        in_sync;
  logic        debounce_en;
  logic [3:0]  fld_stb;
  logic [10:0] conc_code;
  logic [2:0]  maint_code;
  logic [1:0]  alarm_code;
  logic [3:0]  switch_code;
  logic [3:0]  chg_clr;
  logic [10:0] conc_hold;
  logic [2:0]  maint_hold;
  logic [1:0]  alarm_hold;
  logic [3:0]  switch_hold;
  logic [3:0]  chg_flag;

  int checks = 0;
  int errors = 0;

  logic [10:0] m_held [4];
  logic [10:0] m_cmp  [4];
  logic        m_prim [4];
  logic [3:0]  m_flag;

  slc_ovh_extract uut (
    .clk(clk), .rst_n(rst_n), .in_sync(in_sync), .debounce_en(debounce_en),
    .fld_stb(fld_stb), .conc_code(conc_code), .maint_code(maint_code),
    .alarm_code(alarm_code), .switch_code(switch_code), .chg_clr(chg_clr),
    .conc_hold(conc_hold), .maint_hold(maint_hold), .alarm_hold(alarm_hold),
    .switch_hold(switch_hold), .chg_flag(chg_flag)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic logic [10:0] get_held(input int f);
    case (f)
      0: return conc_hold;
      1: return {8'd0, maint_hold};
      2: return {9'd0, alarm_hold};
      default: return {7'd0, switch_hold};
    endcase
  endfunction

  function automatic logic [10:0] wmask(input int f, input logic [10:0] v);
    return v & ((11'd1 << FW[f]) - 11'd1) | (FW[f] == 11 ? v : 11'd0);
  endfunction

  task automatic compare(input string req);
    for (int f = 0; f < 4; f++) begin
      checks++;
      if (get_held(f) !== m_held[f]) begin
        errors++;
        $display("FAIL %s field %0d held: actual %0h expected %0h", req, f, get_held(f), m_held[f]);
      end
    end
    checks++;
    if (chg_flag !== m_flag) begin
      errors++;
      $display("FAIL %s flags: actual %b expected %b", req, chg_flag, m_flag);
    end
  endtask

  task automatic model_reset();
    for (int f = 0; f < 4; f++) begin
      m_held[f] = '0; m_cmp[f] = '0; m_prim[f] = 1'b0;
    end
    m_flag = '0;
  endtask

  // one strobe on field f with code v, optional clears in the same cycle
  task automatic send(input int f, input logic [10:0] v, input logic [3:0] clr, input string req);
    logic [10:0] code;
    logic        load;
    logic        setf;
    code = wmask(f, v);
    @(negedge clk);
    case (f)
      0: conc_code   = code;
      1: maint_code  = code[2:0];
      2: alarm_code  = code[1:0];
      default: switch_code = code[3:0];
    endcase
    fld_stb = 4'b0001 << f;
    chg_clr = clr;
    @(negedge clk);
    fld_stb = '0;
    chg_clr = '0;
    setf = 1'b0;
    if (in_sync) begin
      load = !debounce_en || (code == m_cmp[f]);
      m_cmp[f] = code;
      if (load) begin
        setf = m_prim[f] && (code != m_held[f]);
        m_held[f] = code;
        m_prim[f] = 1'b1;
      end
    end
    m_flag = m_flag & ~clr;
    if (setf) m_flag[f] = 1'b1;
    compare(req);
  endtask

  task automatic clear(input logic [3:0] clr, input string req);
    @(negedge clk);
    chg_clr = clr;
    @(negedge clk);
    chg_clr = '0;
    m_flag = m_flag & ~clr;
    compare(req);
  endtask

  initial begin
    #(20ns * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; in_sync = 1'b0; debounce_en = 1'b0; fld_stb = '0; chg_clr = '0;
    conc_code = '0; maint_code = '0; alarm_code = '0; switch_code = '0;
    model_reset();
    repeat (3) @(negedge clk);
    compare("R1 reset");
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    compare("R1 after release");
    in_sync = 1'b1;

    // R7: first load silent
    send(3, 11'd9, 4'b0, "R7 first load switch");
    send(0, 11'd5, 4'b0, "R7 first load conc");
    // R2, R6
    send(3, 11'd9, 4'b0, "R6 same value no flag");
    send(3, 11'd3, 4'b0, "R6 change sets flag");
    send(0, 11'h7FF, 4'b0, "R10 full scale conc");
    send(1, 11'd7, 4'b0, "R10 full scale maint");
    send(1, 11'd2, 4'b0, "R2 maint direct load");
    // R8
    clear(4'b1000, "R8 clear switch only");
    clear(4'b0000, "R8 flag sticky");
    send(3, 11'd15, 4'b1000, "R8 set wins over clear");
    send(2, 11'd1, 4'b0001, "R9 alarm strobe with conc clear");
    clear(4'b1111, "R8 clear all");

    // R5: out of sync, then comparison frozen
    send(1, 11'd5, 4'b0, "R2 maint load before sync loss");
    in_sync = 1'b0;
    send(1, 11'd2, 4'b0, "R5 ignored out of sync");
    send(0, 11'd1, 4'b0, "R5 ignored conc");
    debounce_en = 1'b1;
    send(1, 11'd2, 4'b0, "R5 compare frozen");
    in_sync = 1'b1;
    send(1, 11'd2, 4'b0, "R5 compare not reloaded while out of sync");
    send(1, 11'd2, 4'b0, "R3 debounce second match");
    // R4
    send(1, 11'd6, 4'b0, "R4 A");
    send(1, 11'd1, 4'b0, "R4 B");
    send(1, 11'd6, 4'b0, "R4 A again no load");
    send(1, 11'd1, 4'b0, "R4 B");
    send(1, 11'd1, 4'b0, "R4 B B loads");
    clear(4'b1111, "R8 clear all");

    // exhaustive alarm three-step sequences, both modes
    for (int d = 0; d < 2; d++) begin
      debounce_en = d[0];
      for (int a = 0; a < 4; a++)
        for (int b = 0; b < 4; b++)
          for (int c = 0; c < 4; c++) begin
            send(2, 11'(a), 4'b0, d ? "R3 alarm sweep" : "R2 alarm sweep");
            send(2, 11'(b), 4'b0, d ? "R4 alarm sweep" : "R6 alarm sweep");
            send(2, 11'(c), 4'b0100, "R6 alarm sweep with clear");
          end
    end

    // maintenance pairs under debounce
    debounce_en = 1'b1;
    for (int a = 0; a < 8; a++)
      for (int b = 0; b < 8; b++) begin
        send(1, 11'(a), 4'b0, "R3 maint pair first");
        send(1, 11'(b), 4'b0, "R3 maint pair second");
      end

    // reset again: flags and held values clear, first load silent again
    @(negedge clk);
    rst_n = 1'b0;
    model_reset();
    @(negedge clk);
    compare("R1 second reset");
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    debounce_en = 1'b0;
    send(2, 11'd3, 4'b0, "R7 first load after second reset");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule